// File: doc/BRIEF.md
# Operand Interlock and Bypass Control

This block decides, for every instruction sitting in the decode stage of a five-stage in-order integer pipeline, where each of its two source operands must come from. It compares the decode-stage source register numbers with the destination tags carried by the execute, memory and write-back pipeline registers. For each operand it picks the youngest producer that is still in flight. It also recognises the one dependency that forwarding cannot cover, a load in execute that feeds the next instruction. In that case it holds fetch and decode for one cycle and puts an empty slot into execute.

A store whose data register is written by the load directly ahead of it is not stalled. Its data operand is marked to be taken from the load result when the store reaches the memory stage. The surrounding datapath owns the multiplexers and the data. This block produces only the select codes, the stall request, the bubble marker and the late store-data bypass strobe. The select codes and strobes are registered, so they line up with the instruction once it has moved into execute.

Top module: `raw_bypass_ctl`

## Requirements
- R1: A source operand matches a stage when that stage's valid and write-enable are both 1 and its destination number equals the source number. The select code for the operand is 1 for an execute-stage producer, 2 for memory, 3 for write-back and 0 for the register file.
- R2: When several stages match the same source, the nearest one wins, in the order execute, then memory, then write-back.
- R3: A source number of 0 never matches, whatever the stage tags hold, and its select code is 0.
- R4: A stage whose valid or write-enable is 0 never matches. A decode slot with valid 0 yields select codes of 0.
- R5: The select codes computed from the decode-stage inputs appear on fwd_a_o and fwd_b_o in the clock cycle after those inputs, once the instruction occupies execute.
- R6: stall_o is 1 in the same cycle as the inputs when a valid decode instruction meets a valid writing load in execute whose destination matches rs, or matches rt of a non-store. In the following cycle bubble_o is 1 and both select codes are 0.
- R7: When a valid decode store's rt alone matches a load in execute, stall_o stays 0 and fwd_b_o is 0 in the next cycle. st_byp_o is 1 two cycles after the decode inputs, while the store sits in the memory stage.
- R8: A store whose rs matches a load in execute stalls as in R6 and raises no store bypass.
- R9: While reset is held and after its release, all outputs are 0 until a dependency is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs | input | RW | First source register number |
| id_rt | input | RW | Second source register number (store data for stores) |
| id_store | input | 1 | Decode instruction is a store |
| ex_valid | input | 1 | Execute slot is occupied |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_rd | input | RW | Execute destination register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory slot is occupied |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_rd | input | RW | Memory destination register |
| wb_valid | input | 1 | Write-back slot is occupied |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_rd | input | RW | Write-back destination register |
| stall_o | output | 1 | Freeze fetch and decode this cycle |
| bubble_o | output | 1 | Execute holds an inserted empty slot |
| fwd_a_o | output | 2 | Source select for rs (0 file, 1 EX, 2 MEM, 3 WB) |
| fwd_b_o | output | 2 | Source select for rt (same coding) |
| st_byp_o | output | 1 | Store in memory stage takes its data from the load in write-back |

## Verification
A wrong priority or a broken comparator shows up at fwd_a_o or fwd_b_o exactly one cycle after the offending decode pattern. A missing stall shows up on stall_o in that same cycle, and on bubble_o one cycle later. Corruption in the two-stage store bypass chain appears on st_byp_o two cycles after the store was in decode, so every internal error reaches a port within two clocks.

// File: rtl/raw_byp_pkg.sv
package raw_byp_pkg;
  // producer stages compared, nearest first: EX, MEM, WB
  localparam int NSTG  = 3;
  localparam int SEL_W = $clog2(NSTG + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/opnd_match.sv
module opnd_match
  import raw_byp_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0]      src,
  input  logic [NSTG-1:0]    live,
  input  logic [NSTG*RW-1:0] dst,
  output logic [NSTG-1:0]    hit,
  output fwd_src_e           sel
);
  // one comparator per in-flight producer
  for (genvar g = 0; g < NSTG; g++) begin : g_cmp
    assign hit[g] = live[g] && (src != '0) && (dst[g*RW +: RW] == src);
  end

  // nearest producer (lowest index) wins
  always_comb begin
    sel = SRC_RF;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (hit[i]) sel = fwd_src_e'(SEL_W'(i + 1));
    end
  end
endmodule

// File: rtl/ld_use_chk.sv
module ld_use_chk (
  input  logic id_valid,
  input  logic id_store,
  input  logic ex_load,
  input  logic rs_hit_ex,
  input  logic rt_hit_ex,
  output logic stall,
  output logic st_fwd
);
  logic rt_needed_now;

  // a store's rt is only consumed in MEM, so it can wait for the load
  assign rt_needed_now = rt_hit_ex && !id_store;
  assign stall  = id_valid && ex_load && (rs_hit_ex || rt_needed_now);
  assign st_fwd = id_valid && ex_load && id_store && rt_hit_ex && !stall;
endmodule

// File: rtl/raw_bypass_ctl.sv
module raw_bypass_ctl
  import raw_byp_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_store,
  input  logic          ex_valid,
  input  logic          ex_wen,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_load,
  input  logic          mem_valid,
  input  logic          mem_wen,
  input  logic [RW-1:0] mem_rd,
  input  logic          wb_valid,
  input  logic          wb_wen,
  input  logic [RW-1:0] wb_rd,
  output logic          stall_o,
  output logic          bubble_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          st_byp_o
);
  logic [NSTG-1:0]    live;
  logic [NSTG*RW-1:0] dst;
  logic [NSTG-1:0]    hit_a, hit_b;
  fwd_src_e           sel_a, sel_b;
  logic               st_fwd;
  logic               st_in_ex;

  // index 0 = EX, 1 = MEM, 2 = WB
  assign live = {wb_valid && wb_wen, mem_valid && mem_wen, ex_valid && ex_wen};
  assign dst  = {wb_rd, mem_rd, ex_rd};

  opnd_match #(.RW(RW)) u_match_a (
    .src(id_rs), .live(live), .dst(dst), .hit(hit_a), .sel(sel_a)
  );

  opnd_match #(.RW(RW)) u_match_b (
    .src(id_rt), .live(live), .dst(dst), .hit(hit_b), .sel(sel_b)
  );

  ld_use_chk u_ld_use (
    .id_valid (id_valid),
    .id_store (id_store),
    .ex_load  (ex_load),
    .rs_hit_ex(hit_a[0]),
    .rt_hit_ex(hit_b[0]),
    .stall    (stall_o),
    .st_fwd   (st_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_a_o  <= '0;
      fwd_b_o  <= '0;
      bubble_o <= 1'b0;
      st_in_ex <= 1'b0;
      st_byp_o <= 1'b0;
    end else begin
      fwd_a_o  <= (stall_o || !id_valid) ? 2'(SRC_RF) : 2'(sel_a);
      fwd_b_o  <= (stall_o || !id_valid || st_fwd) ? 2'(SRC_RF) : 2'(sel_b);
      bubble_o <= stall_o;
      st_in_ex <= st_fwd;
      st_byp_o <= st_in_ex;
    end
  end

  // R3
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (id_rs == '0) |=> (fwd_a_o == 2'd0));

  // R6
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (bubble_o && fwd_a_o == 2'd0 && fwd_b_o == 2'd0));

  // R6
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (ex_load && ex_valid && ex_wen && id_valid));

  // R7
  st_byp_chain_chk: assert property (@(posedge clk) disable iff (rst)
    st_fwd |-> ##2 st_byp_o);

  // R7
  st_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    st_fwd |-> !stall_o);

  // R4
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0 && !bubble_o));
endmodule

// File: tb/raw_bypass_ctl_test.sv
module raw_bypass_ctl_test;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          d_iv, d_st, d_ev, d_ew, d_el, d_mv, d_mw, d_wv, d_ww;
  logic [RW-1:0] d_rs, d_rt, d_erd, d_mrd, d_wrd;
  logic          stall_o, bubble_o, st_byp_o;
  logic [1:0]    fwd_a_o, fwd_b_o;

  raw_bypass_ctl #(.RW(RW)) uut (
    .clk(clk), .rst(rst),
    .id_valid(d_iv), .id_rs(d_rs), .id_rt(d_rt), .id_store(d_st),
    .ex_valid(d_ev), .ex_wen(d_ew), .ex_rd(d_erd), .ex_load(d_el),
    .mem_valid(d_mv), .mem_wen(d_mw), .mem_rd(d_mrd),
    .wb_valid(d_wv), .wb_wen(d_ww), .wb_rd(d_wrd),
    .stall_o(stall_o), .bubble_o(bubble_o),
    .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .st_byp_o(st_byp_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string prev_tag = "R9";
  logic [1:0] e_a = 0, e_b = 0;
  logic       e_bub = 0, e_byp = 0, e_st1 = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic hit_ex(logic [RW-1:0] s);
    return (s != 0) && d_ev && d_ew && (d_erd == s);
  endfunction

  function automatic logic [1:0] exp_sel(logic [RW-1:0] s);
    if (s == 0) return 2'd0;
    if (d_ev && d_ew && d_erd == s) return 2'd1;
    if (d_mv && d_mw && d_mrd == s) return 2'd2;
    if (d_wv && d_ww && d_wrd == s) return 2'd3;
    return 2'd0;
  endfunction

  task automatic cyc(string tag,
                     logic iv, logic [RW-1:0] rs, logic [RW-1:0] rt, logic st,
                     logic ev, logic ew, logic [RW-1:0] erd, logic el,
                     logic mv, logic mw, logic [RW-1:0] mrd,
                     logic wv, logic ww, logic [RW-1:0] wrd);
    logic es, sf;
    @(negedge clk);
    chk({"R5/", prev_tag, " fwd_a"}, fwd_a_o, e_a);
    chk({"R5/", prev_tag, " fwd_b"}, fwd_b_o, e_b);
    chk({"R6/", prev_tag, " bubble"}, bubble_o, e_bub);
    chk({"R7/", prev_tag, " st_byp"}, st_byp_o, e_byp);
    d_iv = iv; d_rs = rs; d_rt = rt; d_st = st;
    d_ev = ev; d_ew = ew; d_erd = erd; d_el = el;
    d_mv = mv; d_mw = mw; d_mrd = mrd;
    d_wv = wv; d_ww = ww; d_wrd = wrd;
    #1;
    es = iv && el && (hit_ex(rs) || (hit_ex(rt) && !st));
    sf = iv && el && st && hit_ex(rt) && !es;
    chk({"R6/", tag, " stall"}, stall_o, es);
    e_a   = (es || !iv) ? 2'd0 : exp_sel(rs);
    e_b   = (es || !iv || sf) ? 2'd0 : exp_sel(rt);
    e_bub = es;
    e_byp = e_st1;
    e_st1 = sf;
    prev_tag = tag;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    {d_iv, d_st, d_ev, d_ew, d_el, d_mv, d_mw, d_wv, d_ww} = '0;
    {d_rs, d_rt, d_erd, d_mrd, d_wrd} = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset fwd_a", fwd_a_o, 0);
    chk("R9 reset fwd_b", fwd_b_o, 0);
    chk("R9 reset stall", stall_o, 0);
    chk("R9 reset bubble", bubble_o, 0);
    chk("R9 reset st_byp", st_byp_o, 0);
    rst = 1'b0;

    // distance 1, 2, 3
    cyc("R1 dist1", 1, 5, 9, 0, 1, 1, 5, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 dist2", 1, 5, 9, 0, 1, 1, 3, 0, 1, 1, 5, 0, 0, 0);
    cyc("R1 dist3", 1, 9, 5, 0, 0, 0, 0, 0, 1, 1, 3, 1, 1, 5);
    // priority
    cyc("R2 all3", 1, 6, 6, 0, 1, 1, 6, 0, 1, 1, 6, 1, 1, 6);
    cyc("R2 mem_wb", 1, 6, 7, 0, 1, 1, 2, 0, 1, 1, 6, 1, 1, 6);
    // register zero
    cyc("R3 zero", 1, 0, 0, 0, 1, 1, 0, 0, 1, 1, 0, 1, 1, 0);
    cyc("R3 zero_load", 1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // valid / write-enable cleared
    cyc("R4 ex_invalid", 1, 4, 4, 0, 0, 1, 4, 1, 0, 0, 0, 0, 0, 0);
    cyc("R4 ex_nowen", 1, 4, 4, 0, 1, 0, 4, 0, 1, 0, 4, 1, 0, 4);
    cyc("R4 id_invalid", 0, 4, 4, 0, 1, 1, 4, 0, 1, 1, 4, 1, 1, 4);
    // load-use on rs, then the pipe moves on
    cyc("R6 lu_rs", 1, 7, 1, 0, 1, 1, 7, 1, 0, 0, 0, 0, 0, 0);
    cyc("R6 after", 1, 7, 1, 0, 0, 0, 0, 0, 1, 1, 7, 0, 0, 0);
    // load-use on rt of a non-store
    cyc("R6 lu_rt", 1, 1, 7, 0, 1, 1, 7, 1, 0, 0, 0, 0, 0, 0);
    cyc("R6 after2", 1, 1, 7, 0, 0, 0, 0, 0, 1, 1, 7, 0, 0, 0);
    // load then store of loaded register
    cyc("R7 ld_st", 1, 2, 8, 1, 1, 1, 8, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7 next", 1, 3, 3, 0, 1, 1, 9, 0, 1, 1, 8, 0, 0, 0);
    cyc("R7 next2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // store address depends on load
    cyc("R8 st_rs", 1, 8, 8, 1, 1, 1, 8, 1, 0, 0, 0, 0, 0, 0);
    cyc("R8 next", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 next2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      cyc("R1 rand", 1'($urandom_range(0, 7) != 0),
          RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          RW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          RW'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          RW'($urandom_range(0, 3)));
    end
    cyc("R1 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule